// File: doc/BRIEF.md
# Incremental Ternary Gate Evaluator

This block evaluates a single multi-input AND, OR, NAND or NOR gate whose inputs carry three-valued logic: 0, 1 and unknown. It never stores or rescans the gate inputs. It keeps two tallies instead. The first counts the inputs that sit at the gate's controlling value. The second counts the inputs that are unknown. The output is worked out from these tallies alone.

A surrounding evaluation engine sends one input-change event per cycle over a valid/ready port. Each event carries the input position, the value that input held before and the value it takes now. The block moves each tally up or down to match. One cycle later it presents the new output, plus a one-cycle flag when that output differs from the previous one.

The gate kind is fixed while reset is held. Events must be consistent: the old value in an event must be the value that input actually held.

Top module: `ternary_count_gate`

## Requirements
- R1: The gate kind is captured from `cfgGate` on every clock edge while `rstN` is low, encoded 00=AND, 01=OR, 10=NAND, 11=NOR. Changes on `cfgGate` while `rstN` is high have no effect on the output.
- R2: Values are coded 00=logic 0, 11=logic 1, 01=unknown. After reset, all `NUM_IN` inputs count as unknown, `outVal` is 01, and `outChanged` and `codeErr` are low.
- R3: When at least one input holds the controlling value (0 for AND/NAND, 1 for OR/NOR), `outVal` equals the controlling value XOR the inversion bit (the inversion bit is 1 for NAND/NOR).
- R4: When no input holds the controlling value but at least one input is unknown, `outVal` is 01.
- R5: When every input holds the non-controlling value, `outVal` is the complement of (controlling value XOR inversion bit).
- R6: An event is accepted on a rising edge where `evValid` and `evReady` are both high. Its old value leaves its tally and its new value joins its tally. The resulting `outVal` is visible after that same edge.
- R7: `outChanged` is high for exactly the cycle after an accepted event whose result differs from the previous `outVal`. It is low in every other cycle.
- R8: An event whose old and new values are equal changes neither `outVal` nor the tallies, and leaves `outChanged` low.
- R9: An accepted event that carries code 10 in its old or new value, or an index of `NUM_IN` or above, raises `codeErr` for the next cycle and leaves the tallies and `outVal` untouched.
- R10: `evReady` is low while `rstN` is low and goes high on the first clock edge after reset is released. Events offered during reset are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| cfgGate | input | 2 | Gate kind, sampled during reset |
| evValid | input | 1 | Event offered |
| evReady | output | 1 | Event port can accept |
| evIdx | input | IDX_W | Position of the changing input |
| evOld | input | 2 | Previous value of that input |
| evNew | input | 2 | New value of that input |
| outVal | output | 2 | Gate output value |
| outChanged | output | 1 | Output differs from its previous value |
| codeErr | output | 1 | Last accepted event was illegal |

## Verification
The bench aims at the boundaries between the three output regions:
- The last controlling input leaving. A design with a wrong decrement would stay stuck at the controlling result.
- The last unknown input resolving. An off-by-one tally would keep reporting unknown.
- Events whose old and new values match. A design that updates tallies blindly would drift here, or would pulse the change flag.

Illegal codes and out-of-range indices are mixed in among legal traffic. A design that lets them touch the tallies would diverge from the model on later events. Events offered during reset, and a configuration change after reset, are also checked: a design that sampled too late would take the wrong gate kind.

// File: rtl/tcg_pkg.sv
package tcg_pkg;

  typedef enum logic [1:0] {
    GATE_AND  = 2'b00,
    GATE_OR   = 2'b01,
    GATE_NAND = 2'b10,
    GATE_NOR  = 2'b11
  } gateKind_t;

  localparam logic [1:0] TV_ZERO = 2'b00;
  localparam logic [1:0] TV_ONE  = 2'b11;
  localparam logic [1:0] TV_UNK  = 2'b01;
  localparam logic [1:0] TV_BAD  = 2'b10;

  // strobes from control to datapath
  typedef struct packed {
    logic take;   // an event was accepted this cycle
    logic ctlDn;  // one input leaves the controlling tally
    logic ctlUp;  // one input joins the controlling tally
    logic unkDn;  // one input leaves the unknown tally
    logic unkUp;  // one input joins the unknown tally
    logic bad;    // accepted event is illegal
  } tallyStrobe_t;

  function automatic logic ctlBitOf(gateKind_t g);
    return (g == GATE_OR) || (g == GATE_NOR);
  endfunction

  function automatic logic invBitOf(gateKind_t g);
    return (g == GATE_NAND) || (g == GATE_NOR);
  endfunction

endpackage

// File: rtl/tcg_ctrl.sv
module tcg_ctrl
  import tcg_pkg::*;
#(
  parameter int NUM_IN = 6,
  parameter int IDX_W  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evValid,
  input  logic [IDX_W-1:0] evIdx,
  input  logic [1:0]       evOld,
  input  logic [1:0]       evNew,
  input  logic [1:0]       ctlCode,
  output logic             evReady,
  output tallyStrobe_t     strobe
);

  logic readyReg;
  logic take;
  logic legal;
  logic moves;

  always_ff @(posedge clk) begin
    if (!rstN) readyReg <= 1'b0;
    else       readyReg <= 1'b1;
  end

  assign evReady = readyReg;
  assign take    = evValid && readyReg;

  always_comb begin
    legal = (evOld != TV_BAD) && (evNew != TV_BAD) && (int'(evIdx) < NUM_IN);
    moves = take && legal && (evOld != evNew);
    strobe.take  = take;
    strobe.bad   = take && !legal;
    strobe.ctlDn = moves && (evOld == ctlCode);
    strobe.ctlUp = moves && (evNew == ctlCode);
    strobe.unkDn = moves && (evOld == TV_UNK);
    strobe.unkUp = moves && (evNew == TV_UNK);
  end

endmodule

// File: rtl/tcg_eval.sv
module tcg_eval
  import tcg_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  gateKind_t        gate,
  input  logic [CNT_W-1:0] ctlCnt,
  input  logic [CNT_W-1:0] unkCnt,
  output logic [1:0]       result
);

  logic forced;

  always_comb begin
    forced = ctlBitOf(gate) ^ invBitOf(gate);
    if (ctlCnt != '0)      result = {2{forced}};
    else if (unkCnt != '0) result = TV_UNK;
    else                   result = {2{~forced}};
  end

endmodule

// File: rtl/tcg_datapath.sv
module tcg_datapath
  import tcg_pkg::*;
#(
  parameter int NUM_IN = 6,
  parameter int CNT_W  = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   cfgGate,
  input  tallyStrobe_t strobe,
  output logic [1:0]   ctlCode,
  output logic [1:0]   outVal,
  output logic         outChanged,
  output logic         codeErr
);

  gateKind_t        gateReg;
  logic [CNT_W-1:0] ctlCnt, unkCnt;
  logic [CNT_W-1:0] ctlNext, unkNext;
  logic [1:0]       nextOut;

  always_ff @(posedge clk) begin
    if (!rstN) gateReg <= gateKind_t'(cfgGate);
  end

  assign ctlCode = ctlBitOf(gateReg) ? TV_ONE : TV_ZERO;

  always_comb begin
    ctlNext = ctlCnt + CNT_W'(strobe.ctlUp) - CNT_W'(strobe.ctlDn);
    unkNext = unkCnt + CNT_W'(strobe.unkUp) - CNT_W'(strobe.unkDn);
  end

  tcg_eval #(.CNT_W(CNT_W)) u_eval (
    .gate  (gateReg),
    .ctlCnt(ctlNext),
    .unkCnt(unkNext),
    .result(nextOut)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlCnt     <= '0;
      unkCnt     <= CNT_W'(NUM_IN);
      outVal     <= TV_UNK;
      outChanged <= 1'b0;
      codeErr    <= 1'b0;
    end else begin
      ctlCnt     <= ctlNext;
      unkCnt     <= unkNext;
      outVal     <= nextOut;
      outChanged <= strobe.take && (nextOut != outVal);
      codeErr    <= strobe.bad;
    end
  end

endmodule

// File: rtl/ternary_count_gate.sv
module ternary_count_gate
  import tcg_pkg::*;
#(
  parameter int NUM_IN = 6,
  localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
  localparam int CNT_W = $clog2(NUM_IN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       cfgGate,
  input  logic             evValid,
  output logic             evReady,
  input  logic [IDX_W-1:0] evIdx,
  input  logic [1:0]       evOld,
  input  logic [1:0]       evNew,
  output logic [1:0]       outVal,
  output logic             outChanged,
  output logic             codeErr
);

  tallyStrobe_t strobe;
  logic [1:0]   ctlCode;

  tcg_ctrl #(.NUM_IN(NUM_IN), .IDX_W(IDX_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .evValid(evValid),
    .evIdx  (evIdx),
    .evOld  (evOld),
    .evNew  (evNew),
    .ctlCode(ctlCode),
    .evReady(evReady),
    .strobe (strobe)
  );

  tcg_datapath #(.NUM_IN(NUM_IN), .CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cfgGate   (cfgGate),
    .strobe    (strobe),
    .ctlCode   (ctlCode),
    .outVal    (outVal),
    .outChanged(outChanged),
    .codeErr   (codeErr)
  );

endmodule

// File: rtl/tcg_checker.sv
module tcg_checker #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             evValid,
  input logic             evReady,
  input logic [IDX_W-1:0] evIdx,
  input logic [1:0]       evOld,
  input logic [1:0]       evNew,
  input logic [1:0]       outVal,
  input logic             outChanged,
  input logic             codeErr
);

  assert_legal_code_R2: assert property (@(posedge clk) disable iff (!rstN)
    outVal != 2'b10);

  assert_err_keeps_out_R9: assert property (@(posedge clk) disable iff (!rstN)
    codeErr |-> outVal == $past(outVal));

  assert_flag_means_change_R7: assert property (@(posedge clk) disable iff (!rstN)
    outChanged |-> outVal != $past(outVal));

  assert_no_flag_no_change_R7: assert property (@(posedge clk) disable iff (!rstN)
    !outChanged |-> outVal == $past(outVal));

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$past(evValid && evReady) |-> (!outChanged && !codeErr));

  assert_same_value_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && evReady && evOld == evNew) |=> !outChanged);

  assert_ready_after_reset_R10: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> evReady);

endmodule

bind ternary_count_gate tcg_checker #(.IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .evValid   (evValid),
  .evReady   (evReady),
  .evIdx     (evIdx),
  .evOld     (evOld),
  .evNew     (evNew),
  .outVal    (outVal),
  .outChanged(outChanged),
  .codeErr   (codeErr)
);

// File: tb/sim_ternary_count_gate.sv
`timescale 1ns/1ps
module sim_ternary_count_gate;

  localparam int NI = 6;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    cfgGate = 2'b00;
  logic          evValid = 1'b0;
  logic          evReady;
  logic [IW-1:0] evIdx = '0;
  logic [1:0]    evOld = 2'b00;
  logic [1:0]    evNew = 2'b00;
  logic [1:0]    outVal;
  logic          outChanged;
  logic          codeErr;

  int nChecks = 0;
  int nFails  = 0;

  logic [1:0] model [NI];
  int         gateSel;
  logic [1:0] expOut;

  always #2 clk = ~clk;

  ternary_count_gate #(.NUM_IN(NI)) u0 (
    .clk(clk), .rstN(rstN), .cfgGate(cfgGate), .evValid(evValid),
    .evReady(evReady), .evIdx(evIdx), .evOld(evOld), .evNew(evNew),
    .outVal(outVal), .outChanged(outChanged), .codeErr(codeErr)
  );

  // expected output by scanning the model (R3, R4, R5)
  function automatic logic [1:0] refOut();
    logic c, inv, anyCtl, anyUnk;
    logic [1:0] cc;
    c   = (gateSel == 1) || (gateSel == 3);
    inv = (gateSel >= 2);
    cc  = c ? 2'b11 : 2'b00;
    anyCtl = 1'b0;
    anyUnk = 1'b0;
    for (int k = 0; k < NI; k++) begin
      if (model[k] == cc)    anyCtl = 1'b1;
      if (model[k] == 2'b01) anyUnk = 1'b1;
    end
    if (anyCtl)      return {2{c ^ inv}};
    else if (anyUnk) return 2'b01;
    else             return {2{~(c ^ inv)}};
  endfunction

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic doReset(input int g);
    @(negedge clk);
    rstN = 1'b0;
    cfgGate = 2'(g);
    evValid = 1'b1;            // offered during reset, must be ignored (R10)
    evIdx = '0; evOld = 2'b01; evNew = 2'b00;
    repeat (3) @(negedge clk);
    check("R10 ready low in reset", {1'b0, evReady}, 2'b00);
    evValid = 1'b0;
    rstN = 1'b1;
    cfgGate = 2'(g ^ 3);       // late change must not matter (R1)
    gateSel = g;
    for (int k = 0; k < NI; k++) model[k] = 2'b01;
    expOut = 2'b01;
    @(negedge clk);
    check("R10 ready after reset", {1'b0, evReady}, 2'b01);
    check("R2 reset output", outVal, 2'b01);
    check("R2 reset flags", {outChanged, codeErr}, 2'b00);
  endtask

  task automatic sendEvent(input int idx, input logic [1:0] oldV, input logic [1:0] newV);
    logic legal;
    logic [1:0] prev;
    legal = (oldV != 2'b10) && (newV != 2'b10) && (idx < NI);
    prev  = expOut;
    if (legal) model[idx] = newV;
    expOut = refOut();
    evIdx = IW'(idx); evOld = oldV; evNew = newV; evValid = 1'b1;
    @(negedge clk);
    evValid = 1'b0;
    if (legal) begin
      check("R6 R3 R4 R5 output after event", outVal, expOut);
      check((oldV == newV) ? "R8 no flag on equal values" : "R7 change flag",
            {1'b0, outChanged}, {1'b0, expOut != prev});
      check("R9 no error on legal event", {1'b0, codeErr}, 2'b00);
    end else begin
      check("R9 illegal keeps output", outVal, prev);
      check("R9 error flag", {outChanged, codeErr}, 2'b01);
    end
  endtask

  function automatic logic [1:0] randVal();
    int r;
    r = $urandom % 3;
    return (r == 0) ? 2'b00 : (r == 1) ? 2'b11 : 2'b01;
  endfunction

  initial begin
    #(4ns * 200000);
    nFails++;
    nChecks++;
    $display("FAIL watchdog expired");
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic [1:0] cc, nc;
    void'($urandom(32'd20240611));
    for (int g = 0; g < 4; g++) begin
      doReset(g);
      cc = ((g == 1) || (g == 3)) ? 2'b11 : 2'b00;
      nc = ~cc;
      // resolve unknowns one by one: last one flips region (R4 -> R5)
      for (int k = 0; k < NI; k++) sendEvent(k, 2'b01, nc);
      check("R5 all non-controlling", outVal, {2{~(cc[0] ^ (g >= 2))}});
      // one controlling input (R3), then remove it (R5)
      sendEvent(2, nc, cc);
      check("R3 one controlling", outVal, {2{cc[0] ^ (g >= 2)}});
      sendEvent(2, cc, cc);       // R8 equal values
      sendEvent(2, cc, 2'b01);    // R4 unknown only
      check("R4 unknown remains", outVal, 2'b01);
      sendEvent(2, 2'b01, nc);
      // illegal encodings and index (R9)
      sendEvent(1, 2'b10, cc);
      sendEvent(1, nc, 2'b10);
      sendEvent(NI, nc, cc);
      sendEvent(1, nc, nc);
      // constrained random traffic
      for (int n = 0; n < 150; n++) begin
        int idx;
        idx = $urandom % NI;
        if (($urandom % 16) == 0) sendEvent(idx, 2'b10, randVal());
        else                      sendEvent(idx, model[idx], randVal());
      end
    end
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule